// File: doc/BRIEF.md
# Eight-to-one transmit serializer with byte-clock return

This block turns a stream of 8-bit words into a single serial bit stream at eight times the word rate, for the transmit side of a SONET/SDH style link. It runs on a fast bit clock from an external frequency synthesizer. It divides that clock by eight to produce a byte clock, which it sends upstream. The upstream framer launches each word on the rising edge of that byte clock and returns a skewed copy of it. The block captures the word on the rising edge of the returned clock. The word crosses into the bit clock domain through a synchronized toggle flag. It is then loaded into a shift register at one fixed phase of the divider and sent most significant bit first.

The parallel side has no valid/ready handshake and no back-pressure. The block takes one word on every returned byte clock edge, and the upstream side must provide one. If the returned clock has no rising edge during a byte period, that slot goes out as eight zero bits. The previous word is never resent.

Top module: `ser8_tx`

## Requirements
- R1: The serial output carries exactly eight bits per byte clock period, one bit per bit clock cycle.
- R2: `word_in` is captured on each rising edge of `byte_clk_in`, and each captured word is sent exactly once.
- R3: `byte_clk_out` is the bit clock divided by eight with 50% duty. After the last cycle of reset, its first rising edge follows the 4th bit clock edge. It is high for four edges and low for four.
- R4: Each word is sent most significant bit first: bit 7 in the first bit slot and bit 0 in the eighth.
- R5: Latency is fixed. Take a word captured after the byte clock rise at bit edge k. Its bit 7 is on `ser_out` from edge k+6, and its bit 0 is on `ser_out` from edge k+13, whatever the skew is.
- R6: Transfer is correct for any delay of the `byte_clk_in` rise after the `byte_clk_out` rise that is above zero and below two bit clock periods. The held word never changes in the cycle it is loaded.
- R7: A byte period with no `byte_clk_in` rising edge produces eight zero bits in its slot. The previous word is not repeated.
- R8: While `rst` is high, sampled on the bit clock, the divider and shift register are cleared, and `ser_out` and `byte_clk_out` are 0. The parallel-side capture register and toggle are cleared directly by `rst`, because their clock is stopped during reset.
- R9: The shift register is loaded only at divider phase 1. On every other bit edge it shifts left by one place and fills with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock from the synthesizer |
| rst | input | 1 | Active-high reset, synchronous to bit_clk |
| byte_clk_in | input | 1 | Returned byte clock from upstream; rising edge captures word_in |
| word_in | input | 8 | Parallel word, bit 7 sent first |
| ser_out | output | 1 | Serial data, one bit per bit_clk cycle |
| byte_clk_out | output | 1 | bit_clk divided by eight, used upstream to launch words |

## Verification
The bench sweeps the returned clock skew across the window, from 1 ns up to just under two bit periods. A design whose load phase sat too close to the capture would then lose words or send half-updated ones at the late end. It gates out whole byte clock pulses, so a design that resends a stale word, or drops the next one, is caught in the gated slot. Every bit is compared on every cycle against a behavioural model. That exposes reversed bit order, a latency that drifts by a cycle with skew, a divider with the wrong phase or duty, and outputs that are not held low in reset.

// File: rtl/ser8_pkg.sv
package ser8_pkg;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned LOAD_PH = 1;
endpackage

// File: rtl/ser8_divider.sv
module ser8_divider #(
  parameter int unsigned W       = ser8_pkg::WORD_W,
  parameter int unsigned LOAD_PH = ser8_pkg::LOAD_PH
) (
  input  logic clk,
  input  logic rst,
  output logic byte_clk,
  output logic load_ph
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (cnt_q == CW'(W - 1)) cnt_nxt = '0;
    else                     cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      byte_clk <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      byte_clk <= (cnt_nxt >= CW'(W / 2));
    end
  end

  assign load_ph = (cnt_q == CW'(LOAD_PH));
endmodule

// File: rtl/ser8_capture.sv
module ser8_capture #(
  parameter int unsigned W = ser8_pkg::WORD_W
) (
  input  logic         pclk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q,
  output logic         tog_q
);
  // byte clock is stopped during reset, so clear without waiting for an edge
  always_ff @(posedge pclk or posedge rst) begin
    if (rst) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      word_q <= din;
      tog_q  <= ~tog_q;
    end
  end
endmodule

// File: rtl/ser8_xfer.sv
module ser8_xfer #(
  parameter int unsigned W      = ser8_pkg::WORD_W,
  parameter int unsigned SYNC_N = ser8_pkg::SYNC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tog_async,
  input  logic [W-1:0] word_async,
  input  logic         load_ph,
  output logic [W-1:0] hold_q,
  output logic         word_rdy
);
  logic [SYNC_N:0] sync_q;
  logic            tog_edge;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-1:0], tog_async};
  end

  assign tog_edge = sync_q[SYNC_N] ^ sync_q[SYNC_N-1];

  // word_async has been still for SYNC_N+ cycles when the edge shows
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      word_rdy <= 1'b0;
    end else if (tog_edge) begin
      hold_q   <= word_async;
      word_rdy <= 1'b1;
    end else if (load_ph) begin
      word_rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/ser8_shift.sv
module ser8_shift #(
  parameter int unsigned W = ser8_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_ph,
  input  logic         word_rdy,
  input  logic [W-1:0] hold_q,
  output logic [W-1:0] shift_q,
  output logic         sd
);
  always_ff @(posedge clk) begin
    if (rst)          shift_q <= '0;
    else if (load_ph) shift_q <= word_rdy ? hold_q : '0;
    else              shift_q <= {shift_q[W-2:0], 1'b0};
  end

  assign sd = shift_q[W-1];
endmodule

// File: rtl/ser8_tx.sv
module ser8_tx #(
  parameter int unsigned W       = ser8_pkg::WORD_W,
  parameter int unsigned SYNC_N  = ser8_pkg::SYNC_N,
  parameter int unsigned LOAD_PH = ser8_pkg::LOAD_PH
) (
  input  logic         bit_clk,
  input  logic         rst,
  input  logic         byte_clk_in,
  input  logic [W-1:0] word_in,
  output logic         ser_out,
  output logic         byte_clk_out
);
  logic         load_ph;
  logic [W-1:0] word_q;
  logic         tog_q;
  logic [W-1:0] hold_q;
  logic         word_rdy;
  logic [W-1:0] shift_q;

  ser8_divider #(.W(W), .LOAD_PH(LOAD_PH)) u_div (
    .clk(bit_clk), .rst(rst), .byte_clk(byte_clk_out), .load_ph(load_ph)
  );

  ser8_capture #(.W(W)) u_cap (
    .pclk(byte_clk_in), .rst(rst), .din(word_in), .word_q(word_q), .tog_q(tog_q)
  );

  ser8_xfer #(.W(W), .SYNC_N(SYNC_N)) u_xfer (
    .clk(bit_clk), .rst(rst), .tog_async(tog_q), .word_async(word_q),
    .load_ph(load_ph), .hold_q(hold_q), .word_rdy(word_rdy)
  );

  ser8_shift #(.W(W)) u_shf (
    .clk(bit_clk), .rst(rst), .load_ph(load_ph), .word_rdy(word_rdy),
    .hold_q(hold_q), .shift_q(shift_q), .sd(ser_out)
  );
endmodule

// File: rtl/ser8_tx_chk.sv
module ser8_tx_chk #(
  parameter int unsigned W = ser8_pkg::WORD_W
) (
  input logic         clk,
  input logic         rst,
  input logic         pclk_out,
  input logic         sd,
  input logic         load_ph,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] hold_q
);
  localparam int unsigned GW = $clog2(W) + 1;

  logic          pclk_prev;
  logic          seen_rise;
  logic [GW-1:0] gap;
  logic          rise;

  assign rise = pclk_out && !pclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_prev <= 1'b0;
      seen_rise <= 1'b0;
      gap       <= '0;
    end else begin
      pclk_prev <= pclk_out;
      if (rise) begin
        seen_rise <= 1'b1;
        gap       <= '0;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  assert_byte_period_R3: assert property (@(posedge clk) disable iff (rst)
    (rise && seen_rise) |-> (gap == GW'(W - 1)));

  assert_shift_only_R9: assert property (@(posedge clk) disable iff (rst)
    !load_ph |=> (shift_q == {$past(shift_q[W-2:0]), 1'b0}));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    load_ph |-> $stable(hold_q));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    $past(rst) |-> (sd == 1'b0 && pclk_out == 1'b0));
endmodule

bind ser8_tx ser8_tx_chk #(.W(W)) u_chk (
  .clk(bit_clk), .rst(rst), .pclk_out(byte_clk_out), .sd(ser_out),
  .load_ph(load_ph), .shift_q(shift_q), .hold_q(hold_q)
);

// File: tb/sim_ser8_tx.sv
`timescale 1ns/1ps
module sim_ser8_tx;
  localparam int W      = 8;
  localparam int NWORDS = 40;

  logic         bit_clk = 1'b0;
  logic         rst;
  logic         byte_clk_in;
  logic [W-1:0] word_in;
  logic         ser_out;
  logic         byte_clk_out;

  logic         pclk_d = 1'b0;
  logic         gate;
  realtime      skew;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  int           k;
  logic [W-1:0] cur;
  logic [W-1:0] q[$];
  logic [W-1:0] launched;
  bit           cur_gap;

  always #10 bit_clk = ~bit_clk;

  ser8_tx u0 (
    .bit_clk(bit_clk), .rst(rst), .byte_clk_in(byte_clk_in), .word_in(word_in),
    .ser_out(ser_out), .byte_clk_out(byte_clk_out)
  );

  always @(byte_clk_out) pclk_d <= #(skew) byte_clk_out;
  assign byte_clk_in = pclk_d & gate;

  // R2: model records each word at the returned clock rise
  always @(posedge byte_clk_in) q.push_back(launched);

  // model: k counts bit edges since reset released, word slot starts at phase 2
  always @(posedge bit_clk) begin
    if (rst) begin
      k = 0; cur = '0; cur_gap = 0;
    end else begin
      k = k + 1;
      if (k % W == 2) begin
        if (q.size() > 0) begin cur = q.pop_front(); cur_gap = 0; end
        else begin cur = '0; cur_gap = (k > 2); end
      end
    end
  end

  always @(negedge bit_clk) begin
    if (!done && rst !== 1'bx) begin
      if (rst) begin
        checks++;
        if (ser_out !== 1'b0 || byte_clk_out !== 1'b0) begin
          errors++;
          $display("FAIL R8 reset: got sd=%b pclk=%b exp 0 0", ser_out, byte_clk_out);
        end
      end else begin
        int p, b;
        logic exp_sd, exp_pc;
        p = k % W;
        b = (p + 6) % W;
        exp_sd = cur[W-1-b];           // R4 MSB first, R5 fixed latency
        exp_pc = (p >= W/2);           // R3 divide by eight
        checks++;
        if (byte_clk_out !== exp_pc) begin
          errors++;
          $display("FAIL R3 k=%0d: got pclk=%b exp %b", k, byte_clk_out, exp_pc);
        end
        checks++;
        if (ser_out !== exp_sd) begin
          errors++;
          if (cur_gap)
            $display("FAIL R7 k=%0d: got sd=%b exp %b", k, ser_out, exp_sd);
          else
            $display("FAIL R4 R5 R1 k=%0d bit %0d of %h: got sd=%b exp %b",
                     k, W-1-b, cur, ser_out, exp_sd);
        end
      end
    end
  end

  function automatic logic [W-1:0] word_of(int i);
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h01;
    if (i == 2) return 8'hFF;
    if (i == 3) return 8'h00;
    return W'((i * 37) ^ 8'hA5);
  endfunction

  function automatic realtime skew_of(int i);
    int s;
    s = 1 + (i * 7) % 38;              // R6: 1 ns .. 38 ns, below two bit periods
    if (s == 20) s = 21;
    return realtime'(s);
  endfunction

  initial begin
    rst = 1'b1; gate = 1'b1; skew = 1.0; word_in = '0; launched = '0;
    repeat (6) @(posedge bit_clk);
    rst <= 1'b0;
    for (int i = 0; i < NWORDS; i++) begin
      @(posedge byte_clk_out);
      word_in  = word_of(i);
      launched = word_of(i);
      @(negedge byte_clk_out);
      #50;
      skew = skew_of(i + 1);
      gate = !((i + 1) == 10 || (i + 1) == 11 || (i + 1) == 25); // R7 gaps
    end
    gate = 1'b1;
    repeat (24) @(posedge bit_clk);
    @(negedge bit_clk);
    done = 1;
    checks++;                          // R2 R6: every captured word consumed once
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 R6 leftover words: got %0d exp 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule